// File: doc/BRIEF.md
# Audio Transmit Frame Buffer Controller

This block sits on the data side of a serial digital audio transmitter. A processor or a DMA engine loads each frame over a simple write bus. The two audio samples of a frame go in as two back-to-back writes to one audio address and land in a two-slot FIFO. The non-audio bits go to a separate holding register, which keeps its value until it is written again.

On every frame-start strobe the block copies the frame into a transmit shift stage. The shift stage holds the left sample, the right sample and the non-audio bits. The block counts frames from the block-start strobe and flags the frame boundary that loads the last frame of a block. It keeps an empty flag that drives a DMA request, and it raises an empty-data interrupt or a block-end interrupt under two enable bits. Sticky status bits record underrun and overflow.

Top module: `afb_tx_frontend`

## Requirements
- R1: A write with `wr_addr`=2 fills the next FIFO slot; the first write of a frame is the left sample and the second is the right sample. At a `frame_start` with a full FIFO, both samples move to `tx_left`/`tx_right`, and `tx_load` is high for exactly the one cycle after each `frame_start` cycle.
- R2: A write with `wr_addr`=1 stores `wr_data[NAW-1:0]` as the non-audio bits. Every frame boundary copies the stored value to `tx_nonaudio`. A value that is not rewritten is sent unchanged in every later frame.
- R3: `empty_flag` is 1 after reset. It sets when a frame boundary drains a full FIFO. A single audio write leaves it set, and the write that completes the pair clears it.
- R4: The frame that comes with `block_start` counts as frame 0. The frame boundary at which the count reaches `FRAMES_PER_BLOCK`-1 sets a block-end event. The event clears when the FIFO is next filled, and `irq_block` is the event gated by control bit 1.
- R5: `irq_empty` is `empty_flag` gated by control bit 0. It is held low while a block-end event is pending and control bit 1 is set. When control bit 1 is clear, the block-end frame raises `irq_empty`.
- R6: `dma_req` equals `empty_flag` whatever the control bits are.
- R7: A `frame_start` while the FIFO is not full is an underrun:
  - the shift stage resends the previous samples;
  - a partially written frame stays in the FIFO;
  - `underrun` sets, and it clears only when 1 is written to bit 0 at `wr_addr`=3.
- R8: An audio write while the FIFO is full and no frame boundary is draining it is ignored. It sets `overflow`, which clears only when 1 is written to bit 1 at `wr_addr`=3. Writing 0 to that bit has no effect.
- R9: The control register at `wr_addr`=0 holds the empty interrupt enable in bit 0 and the block interrupt enable in bit 1. Both bits reset to 0, so both interrupts are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 non-audio, 2 audio, 3 status clear |
| wr_data | input | SW | Write data |
| frame_start | input | 1 | Frame boundary strobe |
| block_start | input | 1 | Marks the frame boundary that begins a block |
| tx_left | output | SW | Shift stage left sample |
| tx_right | output | SW | Shift stage right sample |
| tx_nonaudio | output | NAW | Shift stage non-audio bits |
| tx_load | output | 1 | Pulses when the shift stage is reloaded |
| empty_flag | output | 1 | FIFO needs the next frame |
| dma_req | output | 1 | DMA service request |
| irq_empty | output | 1 | Empty-data interrupt request |
| irq_block | output | 1 | Block-end interrupt request |
| underrun | output | 1 | Sticky underrun status |
| overflow | output | 1 | Sticky overflow status |

## Verification
The hardest case to reach is an underrun that arrives while the FIFO holds exactly one sample. In that case the shift stage must repeat the old pair, and the single stored sample must stay in place to become the left half of the next frame. The stimulus writes one sample, pulses a frame boundary, and then completes the pair. The scoreboard then expects the repeated pair first and the recombined frame second. The block-end path is reached by counting frames from a block-start strobe, with the block length shortened through a parameter. This is run once with the block enable set and once with it clear, so that both interrupt routes are observed.

// File: rtl/afb_pkg.sv
package afb_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL     = 2'd0,
    ADDR_NONAUDIO = 2'd1,
    ADDR_AUDIO    = 2'd2,
    ADDR_STATUS   = 2'd3
  } afb_addr_e;

  localparam int SLOTS         = 2;
  localparam int CTRL_EMPTY_IE = 0;
  localparam int CTRL_BLOCK_IE = 1;
  localparam int STAT_UNDERRUN = 0;
  localparam int STAT_OVERFLOW = 1;
endpackage

// File: rtl/afb_frame_fifo.sv
module afb_frame_fifo #(
  parameter int SW    = 24,
  parameter int SLOTS = 2,
  parameter int LW    = $clog2(SLOTS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                push,
  input  logic                take,
  input  logic [SW-1:0]       din,
  output logic [LW-1:0]       level,
  output logic [SLOTS*SW-1:0] frame
);
  localparam int IW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [SW-1:0] mem [SLOTS];
  logic          full;
  logic          accept;
  logic [IW-1:0] widx;

  assign full   = (level == LW'(SLOTS));
  assign accept = push && (!full || take);
  assign widx   = take ? '0 : level[IW-1:0];

  // storage has no reset so it maps onto plain RAM bits
  always_ff @(posedge clk) begin
    if (accept) mem[widx] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst)       level <= '0;
    else if (take) level <= accept ? LW'(1) : '0;
    else if (accept) level <= level + LW'(1);
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_flat
    assign frame[g*SW +: SW] = mem[g];
  end
endmodule

// File: rtl/afb_block_tracker.sv
module afb_block_tracker #(
  parameter int FRAMES = 192,
  parameter int CW     = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_start,
  input  logic block_start,
  output logic block_end
);
  localparam logic [CW-1:0] LAST = CW'(FRAMES - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_next;

  always_comb begin
    if (block_start)      cnt_next = '0;
    else if (cnt == LAST) cnt_next = '0;
    else                  cnt_next = cnt + CW'(1);
  end

  assign block_end = frame_start && (cnt_next == LAST);

  always_ff @(posedge clk) begin
    if (rst)              cnt <= LAST;
    else if (frame_start) cnt <= cnt_next;
  end
endmodule

// File: rtl/afb_tx_frontend.sv
module afb_tx_frontend #(
  parameter int SW               = 24,
  parameter int NAW              = 4,
  parameter int FRAMES_PER_BLOCK = 192
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [1:0]     wr_addr,
  input  logic [SW-1:0]  wr_data,
  input  logic           frame_start,
  input  logic           block_start,
  output logic [SW-1:0]  tx_left,
  output logic [SW-1:0]  tx_right,
  output logic [NAW-1:0] tx_nonaudio,
  output logic           tx_load,
  output logic           empty_flag,
  output logic           dma_req,
  output logic           irq_empty,
  output logic           irq_block,
  output logic           underrun,
  output logic           overflow
);
  import afb_pkg::*;

  localparam int LW = $clog2(SLOTS + 1);

  logic [LW-1:0]       fifo_level;
  logic [SLOTS*SW-1:0] fifo_frame;
  logic                fifo_full;
  logic                wr_ctrl, wr_na, wr_audio, wr_stat;
  logic                take, fill_done, ovf_hit, und_hit, blk_end;
  logic [1:0]          ctrl_q;
  logic [NAW-1:0]      na_q;
  logic                blk_q;

  assign wr_ctrl  = wr_en && (wr_addr == ADDR_CTRL);
  assign wr_na    = wr_en && (wr_addr == ADDR_NONAUDIO);
  assign wr_audio = wr_en && (wr_addr == ADDR_AUDIO);
  assign wr_stat  = wr_en && (wr_addr == ADDR_STATUS);

  assign fifo_full = (fifo_level == LW'(SLOTS));
  assign take      = frame_start && fifo_full;
  assign und_hit   = frame_start && !fifo_full;
  assign ovf_hit   = wr_audio && fifo_full && !take;
  assign fill_done = wr_audio && !take && (fifo_level == LW'(SLOTS - 1));

  afb_frame_fifo #(.SW(SW), .SLOTS(SLOTS), .LW(LW)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (wr_audio),
    .take  (take),
    .din   (wr_data),
    .level (fifo_level),
    .frame (fifo_frame)
  );

  afb_block_tracker #(.FRAMES(FRAMES_PER_BLOCK)) u_blk (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .block_start (block_start),
    .block_end   (blk_end)
  );

  // control and non-audio holding registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      na_q   <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wr_data[1:0];
      if (wr_na)   na_q   <= wr_data[NAW-1:0];
    end
  end

  // transmit shift stage
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_left     <= '0;
      tx_right    <= '0;
      tx_nonaudio <= '0;
      tx_load     <= 1'b0;
    end else begin
      tx_load <= frame_start;
      if (frame_start) tx_nonaudio <= na_q;
      if (take) begin
        tx_left  <= fifo_frame[0 +: SW];
        tx_right <= fifo_frame[SW +: SW];
      end
    end
  end

  // flags: a frame boundary takes priority over a same-cycle clear
  always_ff @(posedge clk) begin
    if (rst) begin
      empty_flag <= 1'b1;
      blk_q      <= 1'b0;
      underrun   <= 1'b0;
      overflow   <= 1'b0;
    end else begin
      if (take)           empty_flag <= 1'b1;
      else if (fill_done) empty_flag <= 1'b0;

      if (blk_end)        blk_q <= 1'b1;
      else if (fill_done) blk_q <= 1'b0;

      if (und_hit)        underrun <= 1'b1;
      else if (wr_stat && wr_data[STAT_UNDERRUN]) underrun <= 1'b0;

      if (ovf_hit)        overflow <= 1'b1;
      else if (wr_stat && wr_data[STAT_OVERFLOW]) overflow <= 1'b0;
    end
  end

  // request outputs decode registers only
  assign dma_req   = empty_flag;
  assign irq_block = blk_q && ctrl_q[CTRL_BLOCK_IE];
  assign irq_empty = empty_flag && ctrl_q[CTRL_EMPTY_IE] &&
                     !(blk_q && ctrl_q[CTRL_BLOCK_IE]);
endmodule

// File: rtl/afb_tx_frontend_chk.sv
module afb_tx_frontend_chk #(
  parameter int SW = 24,
  parameter int LW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          frame_start,
  input logic          wr_en,
  input logic [1:0]    wr_addr,
  input logic [LW-1:0] level,
  input logic          tx_load,
  input logic [SW-1:0] tx_left,
  input logic [SW-1:0] tx_right,
  input logic          empty_flag,
  input logic          irq_empty,
  input logic          irq_block,
  input logic          underrun,
  input logic          overflow
);
  import afb_pkg::*;

  localparam logic [LW-1:0] FULL = LW'(SLOTS);

  assert_load_after_frame_R1: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> tx_load);

  assert_no_stray_load_R1: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> !tx_load);

  assert_empty_tracks_level_R3: assert property (@(posedge clk) disable iff (rst)
    empty_flag == (level != FULL));

  assert_empty_after_drain_R3: assert property (@(posedge clk) disable iff (rst)
    (frame_start && level == FULL) |=> empty_flag);

  assert_irq_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    !(irq_empty && irq_block));

  assert_underrun_repeat_R7: assert property (@(posedge clk) disable iff (rst)
    (frame_start && level != FULL) |=>
      (underrun && $stable(tx_left) && $stable(tx_right)));

  assert_overflow_on_full_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_AUDIO && level == FULL && !frame_start) |=> overflow);
endmodule

bind afb_tx_frontend afb_tx_frontend_chk #(.SW(SW), .LW(LW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .frame_start (frame_start),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .level       (fifo_level),
  .tx_load     (tx_load),
  .tx_left     (tx_left),
  .tx_right    (tx_right),
  .empty_flag  (empty_flag),
  .irq_empty   (irq_empty),
  .irq_block   (irq_block),
  .underrun    (underrun),
  .overflow    (overflow)
);

// File: tb/sim_afb_tx_frontend.sv
`timescale 1ns/1ps
module sim_afb_tx_frontend;
  localparam int SW = 24;
  localparam int NAW = 4;
  localparam int FRAMES = 4;
  localparam int XW = 2*SW + NAW;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           wr_en = 1'b0;
  logic [1:0]     wr_addr = '0;
  logic [SW-1:0]  wr_data = '0;
  logic           frame_start = 1'b0;
  logic           block_start = 1'b0;
  logic [SW-1:0]  tx_left, tx_right;
  logic [NAW-1:0] tx_nonaudio;
  logic           tx_load, empty_flag, dma_req, irq_empty, irq_block, underrun, overflow;

  int n_chk = 0;
  int n_fail = 0;
  logic [XW-1:0] exp_q[$];

  logic [SW-1:0]  m_fifo [2];
  int             m_lvl = 0;
  logic [SW-1:0]  m_l = '0, m_r = '0;
  logic [NAW-1:0] m_na = '0;

  always #10 clk = ~clk;

  afb_tx_frontend #(.SW(SW), .NAW(NAW), .FRAMES_PER_BLOCK(FRAMES)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_start(frame_start), .block_start(block_start),
    .tx_left(tx_left), .tx_right(tx_right), .tx_nonaudio(tx_nonaudio),
    .tx_load(tx_load), .empty_flag(empty_flag), .dma_req(dma_req),
    .irq_empty(irq_empty), .irq_block(irq_block),
    .underrun(underrun), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [SW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    if (a == 2'd2 && m_lvl < 2) begin m_fifo[m_lvl] = d; m_lvl++; end
    if (a == 2'd1) m_na = d[NAW-1:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver: pushes the frame the shift stage must show after this boundary
  task automatic frame_pulse(input bit blk);
    @(negedge clk);
    frame_start = 1'b1; block_start = blk;
    if (m_lvl == 2) begin m_l = m_fifo[0]; m_r = m_fifo[1]; m_lvl = 0; end
    exp_q.push_back({m_l, m_r, m_na});
    @(negedge clk);
    frame_start = 1'b0; block_start = 1'b0;
  endtask

  task automatic fill(input logic [SW-1:0] a, input logic [SW-1:0] b);
    bus_wr(2'd2, a);
    bus_wr(2'd2, b);
  endtask

  // monitor: compares every shift-stage load with the scoreboard (R1, R2)
  always @(negedge clk) begin
    if (!rst && tx_load) begin
      if (exp_q.size() == 0) chk(1'b0, "R1 unexpected load", 64'(tx_left), 64'(0));
      else begin
        logic [XW-1:0] e;
        e = exp_q.pop_front();
        chk({tx_left, tx_right} == e[XW-1:NAW], "R1 frame samples",
            64'({tx_left, tx_right}), 64'(e[XW-1:NAW]));
        chk(tx_nonaudio == e[NAW-1:0], "R2 non-audio bits",
            64'(tx_nonaudio), 64'(e[NAW-1:0]));
      end
    end
  end

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(empty_flag == 1'b1, "R3 reset empty", 64'(empty_flag), 64'(1));
    chk(dma_req == 1'b1, "R6 reset dma", 64'(dma_req), 64'(1));
    chk({irq_empty, irq_block} == 2'b00, "R9 reset irqs", 64'({irq_empty, irq_block}), 64'(0));
    chk({underrun, overflow, tx_load} == 3'b000, "R7 R8 reset status", 64'({underrun, overflow}), 64'(0));

    bus_wr(2'd0, 24'd1);
    chk(irq_empty == 1'b1, "R5 empty irq enabled", 64'(irq_empty), 64'(1));
    bus_wr(2'd0, 24'd3);
    chk({irq_empty, irq_block} == 2'b10, "R9 both enables no block", 64'({irq_empty, irq_block}), 64'(2));

    bus_wr(2'd1, 24'h5);
    bus_wr(2'd2, 24'h111);
    chk(empty_flag == 1'b1, "R3 one write keeps empty", 64'(empty_flag), 64'(1));
    bus_wr(2'd2, 24'h222);
    chk(empty_flag == 1'b0, "R3 pair clears empty", 64'(empty_flag), 64'(0));
    chk({dma_req, irq_empty} == 2'b00, "R6 dma drops", 64'({dma_req, irq_empty}), 64'(0));
    frame_pulse(1'b1);
    chk(empty_flag == 1'b1, "R3 drain sets empty", 64'(empty_flag), 64'(1));

    for (int i = 1; i < FRAMES; i++) begin
      fill(SW'(24'h300 + i), SW'(24'h400 + i));
      frame_pulse(1'b0);
      if (i < FRAMES - 1)
        chk(irq_block == 1'b0, "R4 no early block end", 64'(irq_block), 64'(0));
    end
    chk({irq_block, irq_empty} == 2'b10, "R4 R5 block end replaces empty", 64'({irq_block, irq_empty}), 64'(2));
    fill(24'h501, 24'h502);
    chk(irq_block == 1'b0, "R4 refill clears block event", 64'(irq_block), 64'(0));

    bus_wr(2'd0, 24'd1);
    frame_pulse(1'b1);
    for (int i = 1; i < FRAMES; i++) begin
      if (i == 2) bus_wr(2'd1, 24'ha);
      fill(SW'(24'h600 + i), SW'(24'h700 + i));
      frame_pulse(1'b0);
    end
    chk({irq_block, irq_empty} == 2'b01, "R5 block end with block irq off", 64'({irq_block, irq_empty}), 64'(1));

    bus_wr(2'd0, 24'd0);
    chk({dma_req, irq_empty} == 2'b10, "R6 dma without enables", 64'({dma_req, irq_empty}), 64'(2));

    frame_pulse(1'b0);
    chk(underrun == 1'b1, "R7 underrun set", 64'(underrun), 64'(1));
    bus_wr(2'd3, 24'd2);
    chk(underrun == 1'b1, "R7 wrong bit keeps underrun", 64'(underrun), 64'(1));
    bus_wr(2'd3, 24'd1);
    chk(underrun == 1'b0, "R7 underrun cleared", 64'(underrun), 64'(0));

    bus_wr(2'd2, 24'h8a1);
    frame_pulse(1'b0);
    chk(underrun == 1'b1, "R7 partial frame underrun", 64'(underrun), 64'(1));
    bus_wr(2'd2, 24'h8b2);
    chk(empty_flag == 1'b0, "R7 kept sample completes pair", 64'(empty_flag), 64'(0));
    frame_pulse(1'b0);
    bus_wr(2'd3, 24'd1);

    fill(24'h9c1, 24'h9d2);
    bus_wr(2'd2, 24'hbad);
    chk(overflow == 1'b1, "R8 overflow set", 64'(overflow), 64'(1));
    frame_pulse(1'b0);
    bus_wr(2'd3, 24'd0);
    chk(overflow == 1'b1, "R8 zero write keeps overflow", 64'(overflow), 64'(1));
    bus_wr(2'd3, 24'd2);
    chk(overflow == 1'b0, "R8 overflow cleared", 64'(overflow), 64'(0));

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R1 all frames loaded", 64'(exp_q.size()), 64'(0));
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule